// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block gathers the interrupt sources of a small 8-bit core into a single control register: one external pin with selectable edge sense, a one-cycle timer wrap pulse, and a four-bit slice of an I/O port. It also drives an interrupt request and a wake signal toward the core. The core reads and writes the register as a whole. A port-read strobe refreshes a stored copy of the port slice, and the copy is what later changes are measured against.

The external pin and the port slice each pass through a two-stage synchroniser. A two-state machine follows the synchronised pin level. Its states are `PIN_LOW` and `PIN_HIGH`. It goes from `PIN_LOW` to `PIN_HIGH` when the level becomes 1 and from `PIN_HIGH` to `PIN_LOW` when the level becomes 0. The low-to-high transition reports an edge when the rising sense is selected, and the high-to-low transition reports one when the falling sense is selected.

Register layout:

| Bit | Role |
|-----|------|
| 7 | master enable |
| 6 | reads 0 |
| 5 | timer enable |
| 4 | pin enable |
| 3 | port enable |
| 2 | timer flag |
| 1 | pin flag |
| 0 | port flag |

Wake depends only on the individual enables, while the request also needs the master enable.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the register reads 8'h00, and `irq_req` and `wake_req` are low.
- R2: With `edge_rise_sel`=1, a 0→1 change on `ext_pin` sets bit 1 on the third rising clock edge after the change, and not earlier. A 1→0 change sets nothing.
- R3: With `edge_rise_sel`=0, a 1→0 change on `ext_pin` sets bit 1, and a 0→1 change sets nothing.
- R4: A `tmr_ovf` pulse sets bit 2 on the next clock edge.
- R5: While the synchronised `port_hi` differs from the snapshot, bit 0 is set every cycle. A `port_rd` strobe loads the snapshot from the synchronised port value, after which the flag can stay cleared.
- R6: The hardware never clears a flag. A register write with a 0 in a flag position clears that flag.
- R7: If a write clears a flag in the same cycle that a set event for that flag occurs, the flag ends up set.
- R8: `wake_req` is 1 exactly when some flag (bit 2, 1, 0) is 1 together with its enable (bit 5, 4, 3 respectively), whatever the value of bit 7.
- R9: `irq_req` is 1 exactly when `wake_req` is 1 and bit 7 is 1.
- R10: Bit 6 always reads 0, and writing a 1 to it has no effect.
- R11: A register write stores bits 7 and 5..3 as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| edge_rise_sel | input | 1 | 1: pin flag on rising edge, 0: on falling edge |
| ext_pin | input | 1 | asynchronous external interrupt pin |
| tmr_ovf | input | 1 | one-cycle pulse when the timer wraps from FFh to 00h |
| port_hi | input | PORT_W | asynchronous upper port bits |
| port_rd | input | 1 | port-read strobe, reloads the snapshot |
| reg_wr | input | 1 | register write strobe |
| reg_wdata | input | 8 | register write data |
| reg_rdata | output | 8 | register contents |
| irq_req | output | 1 | interrupt request to the core |
| wake_req | output | 1 | wake-up from sleep |

## Verification
The pin path is driven with both edge directions under both sense settings. This separates a correct polarity choice from an inverted or edge-blind detector, and an early-sample check separates the two-stage latency from a shorter path. The port path is tried with a mismatch that persists across a software clear and then with a read strobe that resolves it, which tells a snapshot comparison apart from a one-shot change pulse. The timer path is driven both alone and together with a clearing write, which exposes the set-over-clear priority. Enable patterns with and without the master bit separate the wake rule from the request rule.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned B_GIE   = 7;
    localparam int unsigned B_RSVD  = 6;
    localparam int unsigned B_TEN   = 5;
    localparam int unsigned B_XEN   = 4;
    localparam int unsigned B_PEN   = 3;
    localparam int unsigned B_TFLG  = 2;
    localparam int unsigned B_XFLG  = 1;
    localparam int unsigned B_PFLG  = 0;
    localparam logic [REG_W-1:0] WR_MASK = 8'hBF;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_sel,
    input  logic pin_s,
    output logic edge_hit
);
    pin_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        edge_hit = 1'b0;
        unique case (state_q)
            PIN_LOW: begin
                if (pin_s) begin
                    state_d  = PIN_HIGH;
                    edge_hit = rise_sel;
                end
            end
            PIN_HIGH: begin
                if (!pin_s) begin
                    state_d  = PIN_LOW;
                    edge_hit = !rise_sel;
                end
            end
            default: state_d = PIN_LOW;
        endcase
    end

    // R2/R3: an edge report always coincides with a state move
    a_r2_edge_moves_state: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (state_q != $past(state_q)));
    // R3: no edge report without the pin level moving away from the state
    a_r3_edge_needs_level_change: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_LOW && !pin_s) |-> !edge_hit);
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
    parameter int unsigned PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_s,
    input  logic              rd_stb,
    output logic              mismatch
);
    logic [PORT_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      snap_q <= '0;
        else if (rd_stb) snap_q <= port_s;
    end

    assign mismatch = (port_s != snap_q);

    // R5: the snapshot only moves on a read strobe
    a_r5_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(snap_q));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PORT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_rise_sel,
    input  logic              ext_pin,
    input  logic              tmr_ovf,
    input  logic [PORT_W-1:0] port_hi,
    input  logic              port_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_req,
    output logic              wake_req
);
    logic              pin_s;
    logic [PORT_W-1:0] port_s;
    logic              pin_edge;
    logic              port_chg;
    logic [REG_W-1:0]  ctl_q, ctl_d;
    logic [2:0]        pend;

    irq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_async(ext_pin), .q_sync(pin_s));

    irq_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
        .clk(clk), .rst_n(rst_n), .d_async(port_hi), .q_sync(port_s));

    irq_edge_fsm u_edge (
        .clk(clk), .rst_n(rst_n), .rise_sel(edge_rise_sel),
        .pin_s(pin_s), .edge_hit(pin_edge));

    irq_port_watch #(.PORT_W(PORT_W)) u_port (
        .clk(clk), .rst_n(rst_n), .port_s(port_s),
        .rd_stb(port_rd), .mismatch(port_chg));

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // software write first, hardware set events override it
    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr) ctl_d = reg_wdata & WR_MASK;
        if (tmr_ovf)  ctl_d[B_TFLG] = 1'b1;
        if (pin_edge) ctl_d[B_XFLG] = 1'b1;
        if (port_chg) ctl_d[B_PFLG] = 1'b1;
    end

    always_comb begin
        pend[0]   = ctl_q[B_PFLG] & ctl_q[B_PEN];
        pend[1]   = ctl_q[B_XFLG] & ctl_q[B_XEN];
        pend[2]   = ctl_q[B_TFLG] & ctl_q[B_TEN];
        wake_req  = |pend;
        irq_req   = wake_req & ctl_q[B_GIE];
        reg_rdata = ctl_q;
    end

    a_r6_tflag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_TFLG] && !reg_wr) |=> ctl_q[B_TFLG]);
    a_r6_xflag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_XFLG] && !reg_wr) |=> ctl_q[B_XFLG]);
    a_r4_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> reg_rdata[B_TFLG]);
    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (port_chg && reg_wr && !reg_wdata[B_PFLG]) |=> reg_rdata[B_PFLG]);
    a_r9_irq_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wake_req);
    a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[B_RSVD]);
endmodule

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       edge_rise_sel = 1'b1;
    logic       ext_pin = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic [3:0] port_hi = 4'h0;
    logic       port_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req, wake_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_flag_ctrl i_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .edge_rise_sel(edge_rise_sel),
        .ext_pin(ext_pin), .tmr_ovf(tmr_ovf), .port_hi(port_hi),
        .port_rd(port_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .wake_req(wake_req));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 irq", {7'b0, irq_req}, 8'h00);
        chk("R1 wake", {7'b0, wake_req}, 8'h00);
    endtask

    task automatic t_rise;
        edge_rise_sel = 1'b1;
        ext_pin = 1'b1;
        cyc(2);
        chk("R2 latency", reg_rdata & 8'h02, 8'h00);
        cyc(1);
        chk("R2 rise sets", reg_rdata & 8'h02, 8'h02);
        wr(8'h00);
        ext_pin = 1'b0;
        cyc(4);
        chk("R2 fall ignored", reg_rdata & 8'h02, 8'h00);
    endtask

    task automatic t_fall;
        edge_rise_sel = 1'b0;
        ext_pin = 1'b1;
        cyc(4);
        chk("R3 rise ignored", reg_rdata & 8'h02, 8'h00);
        ext_pin = 1'b0;
        cyc(3);
        chk("R3 fall sets", reg_rdata & 8'h02, 8'h02);
        cyc(3);
        chk("R6 sticky", reg_rdata & 8'h02, 8'h02);
        wr(8'h00);
        chk("R6 write clears", reg_rdata, 8'h00);
        edge_rise_sel = 1'b1;
    endtask

    task automatic t_timer;
        tmr_ovf = 1'b1;
        cyc(1);
        tmr_ovf = 1'b0;
        chk("R4 timer sets", reg_rdata & 8'h04, 8'h04);
        // R7: clear and set in the same cycle
        reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1;
        cyc(1);
        reg_wr = 1'b0; tmr_ovf = 1'b0;
        chk("R7 set wins", reg_rdata & 8'h04, 8'h04);
        wr(8'h00);
    endtask

    task automatic t_port;
        port_hi = 4'b0100;
        cyc(3);
        chk("R5 mismatch sets", reg_rdata & 8'h01, 8'h01);
        wr(8'h00);
        chk("R5 persists", reg_rdata & 8'h01, 8'h01);
        port_rd = 1'b1;
        cyc(1);
        port_rd = 1'b0;
        wr(8'h00);
        cyc(3);
        chk("R5 resolved by read", reg_rdata & 8'h01, 8'h00);
    endtask

    task automatic t_enables;
        wr(8'h38);
        chk("R11 store", reg_rdata, 8'h38);
        wr(8'h40);
        chk("R10 rsvd", reg_rdata, 8'h00);
        wr(8'h20);
        tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
        chk("R8 wake no gie", {6'b0, irq_req, wake_req}, 8'h01);
        wr(8'hA4);
        chk("R9 irq with gie", {6'b0, irq_req, wake_req}, 8'h03);
        wr(8'h84);
        chk("R8 flag w/o enable", {6'b0, irq_req, wake_req}, 8'h00);
        wr(8'h10);
        chk("R8 no flag", {6'b0, irq_req, wake_req}, 8'h00);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset;
        t_rise;
        t_fall;
        t_timer;
        t_port;
        t_enables;
        finish_run;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run;
    end
endmodule